// File: doc/BRIEF.md
# Flash Command Sequencer and Status Register

This block is the command front end of a NOR-style flash. Software writes command bytes on a simple synchronous write port. The block decodes them into read-mode selection, status clearing, and program, erase and lock-bit operations. Setup codes must be followed by a confirm code. A page program takes a setup code followed by a run of data writes at increasing page offsets. The operation itself runs against an abstract array engine. The block issues one-cycle start pulses to it and times the operation with an internal cycle counter. It samples a fail flag and an over-program flag from the engine at the moment the operation completes.

The read side is a multiplexer that the current read mode steers. It returns array data passed through from the array, the identifier bytes, the status byte, or the lock state of the addressed block. An active-low reset input doubles as power-down. Asserting it aborts any running operation, restores read-array mode and loads the status byte with 80h. Lock bits are held per block. They protect a block only while the write-protect input is low.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read mode is array (rd_mode 0), rd_data passes arr_rdata through, rdy_busy is 1 and the status byte reads 80h.
- R2: Writes of FFh, 90h, 70h and 71h select read modes 0 (array), 1 (identifier), 2 (status) and 3 (lock status) on rd_mode. The status byte is {ready, suspended, erase error, program error, block error, 000}, with ready in bit 7 and the erase error in bit 5.
- R3: In identifier mode, rd_addr bit 0 = 0 returns 07h. rd_addr bit 0 = 1 returns 85h when TOP_BOOT is 1 and 86h otherwise.
- R4: The pair 20h then D0h starts a block erase on the block in the top BLK_W address bits of the second write. arr_erase_go pulses in the cycle after the confirm, arr_blk names that block, and rdy_busy stays low for exactly ERASE_CYC cycles.
- R5: The pair 77h then D0h sets the lock bit of the addressed block after PROG_CYC busy cycles. The pair A7h then D0h starts an erase of all blocks, pulsing arr_erase_go and arr_erase_all together. In lock-status mode, bit 6 of rd_data is 1 for an unlocked block, and all other bits are 0.
- R6: 41h followed by 2^PAGE_W data writes whose low PAGE_W address bits equal 0, 1, 2, ... loads a page. Each load pulses arr_ld with its address and data, and the last one starts a program of PROG_CYC cycles with an arr_prog_go pulse. A write at the wrong offset abandons the load as a sequence error.
- R7: A setup code (20h, 77h, A7h) followed by anything other than D0h sets status bits 5 and 4 together and starts nothing.
- R8: B0h during an operation suspends it. The status shows bit 7 = 1 and bit 6 = 1, arr_hold is 1 and the cycle count freezes. D0h resumes it with the remaining count.
- R9: At completion, an engine fail sets bit 5 for an erase, or bit 4 for a program or lock-bit program. An over-program flag at program completion sets bit 3. These bits persist across later operations until a 50h write or a reset.
- R10: With wp_n low, an erase confirm or the final page write to a locked block sets bit 5 or bit 4 at once and starts nothing. An erase completing with wp_n high clears the lock bits of the erased blocks.
- R11: Accepting an operation, a sequence error, a lock rejection or a suspend switches the read mode to status. Only a read-mode command changes it after that.
- R12: Driving rst_n low during an operation aborts it. After release the block is ready in array mode with status 80h.
- R13: While busy or suspended, any command other than a read-mode code, 50h, B0h (while busy) or D0h (while suspended) is ignored.
- R14: rdy_busy is low exactly while status bit 7 is 0, and status bits 2 to 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down, asynchronous |
| cmd_valid | input | 1 | Command write strobe, one cycle per write |
| cmd_addr | input | ADDR_W | Write address |
| cmd_data | input | 8 | Command or data byte |
| wp_n | input | 1 | Write protect, low enables lock bits |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | 8 | Array read data |
| arr_fail | input | 1 | Engine fail flag, sampled at completion |
| arr_ovp | input | 1 | Engine over-program flag, sampled at program completion |
| rd_mode | output | 2 | Current read mode |
| rd_data | output | 8 | Read data for the current mode |
| rdy_busy | output | 1 | High when ready, low while busy |
| arr_prog_go | output | 1 | Program start pulse |
| arr_erase_go | output | 1 | Erase start pulse |
| arr_erase_all | output | 1 | Qualifies arr_erase_go as an all-block erase |
| arr_hold | output | 1 | Operation suspended |
| arr_blk | output | BLK_W | Block of the current operation |
| arr_ld | output | 1 | Page data load pulse |
| arr_ld_addr | output | ADDR_W | Page load address |
| arr_ld_data | output | 8 | Page load data |

## Verification
Every command write is registered on one rising edge. Its effects on rd_mode, the status byte, the start pulses and arr_ld are therefore due one edge later, and the bench samples them at the falling edge that follows the write. The identifier and lock-status outputs are combinational in rd_addr, so they are sampled one nanosecond after rd_addr changes. Busy windows are counted edge by edge: rdy_busy must still be low ERASE_CYC-1 or PROG_CYC-1 falling edges after the first busy sample and high on the next one. After a resume, the window shrinks by the number of busy cycles spent before the suspend.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int ADDR_W    = 16,
  parameter int BLK_W     = 3,
  parameter int PAGE_W    = 3,
  parameter int ERASE_CYC = 40,
  parameter int PROG_CYC  = 20,
  parameter bit TOP_BOOT  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_rdata,
  input  logic              arr_fail,
  input  logic              arr_ovp,
  output logic [1:0]        rd_mode,
  output logic [7:0]        rd_data,
  output logic              rdy_busy,
  output logic              arr_prog_go,
  output logic              arr_erase_go,
  output logic              arr_erase_all,
  output logic              arr_hold,
  output logic [BLK_W-1:0]  arr_blk,
  output logic              arr_ld,
  output logic [ADDR_W-1:0] arr_ld_addr,
  output logic [7:0]        arr_ld_data
);
  localparam int NBLK    = 1 << BLK_W;
  localparam int CNT_MAX = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [PAGE_W-1:0] LAST_OFF = {PAGE_W{1'b1}};
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? 8'h85 : 8'h86;

  localparam logic [1:0] M_ARR = 2'd0, M_ID = 2'd1, M_STS = 2'd2, M_LCK = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOAD, S_BUSY, S_SUSP} state_t;
  typedef enum logic [1:0] {K_ERASE, K_EALL, K_PROG, K_LOCK} kind_t;

  state_t            state;
  kind_t             kind;
  logic [1:0]        mode;
  logic [7:0]        pend;
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W-1:0] idx;
  logic [BLK_W-1:0]  blk;
  logic              e5, p4, b3;
  logic [NBLK-1:0]   lock;
  logic              s5, s4, s3, clr;

  wire [BLK_W-1:0] wblk = cmd_addr[ADDR_W-1 -: BLK_W];
  wire [BLK_W-1:0] rblk = rd_addr[ADDR_W-1 -: BLK_W];
  wire [BLK_W-1:0] cblk = (idx == '0) ? wblk : blk;
  wire             busy = (state == S_BUSY);
  wire             susp = (state == S_SUSP);
  wire             fin  = busy && (cnt == CNT_W'(1));
  wire             open_st = (state == S_IDLE) || busy || susp;
  wire             off_ok  = (cmd_addr[PAGE_W-1:0] == idx);
  wire             is_rd   = (cmd_data == 8'hFF) || (cmd_data == 8'h90) ||
                             (cmd_data == 8'h70) || (cmd_data == 8'h71);
  logic [1:0]      rd_code;
  logic            unused_bits;

  assign unused_bits = ^{rd_addr, cmd_addr};

  always_comb begin
    case (cmd_data)
      8'h90:   rd_code = M_ID;
      8'h70:   rd_code = M_STS;
      8'h71:   rd_code = M_LCK;
      default: rd_code = M_ARR;
    endcase
  end

  always_comb begin
    s5 = 1'b0; s4 = 1'b0; s3 = 1'b0;
    if (fin) begin
      if (kind == K_ERASE || kind == K_EALL) s5 = arr_fail;
      else begin
        s4 = arr_fail;
        s3 = (kind == K_PROG) && arr_ovp;
      end
    end
    if (cmd_valid && state == S_SETUP) begin
      if (cmd_data != 8'hD0) begin
        s5 = 1'b1; s4 = 1'b1;
      end else if (pend == 8'h20 && lock[wblk] && !wp_n) s5 = 1'b1;
    end
    if (cmd_valid && state == S_LOAD) begin
      if (!off_ok) begin
        s5 = 1'b1; s4 = 1'b1;
      end else if (idx == LAST_OFF && lock[cblk] && !wp_n) s4 = 1'b1;
    end
  end

  assign clr = cmd_valid && open_st && (cmd_data == 8'h50);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_ERASE; mode <= M_ARR; pend <= '0;
      cnt <= '0; idx <= '0; blk <= '0;
      e5 <= 1'b0; p4 <= 1'b0; b3 <= 1'b0; lock <= '0;
      arr_prog_go <= 1'b0; arr_erase_go <= 1'b0; arr_erase_all <= 1'b0;
      arr_ld <= 1'b0; arr_ld_addr <= '0; arr_ld_data <= '0;
    end else begin
      arr_prog_go <= 1'b0; arr_erase_go <= 1'b0; arr_erase_all <= 1'b0;
      arr_ld <= 1'b0;
      e5 <= (e5 & ~clr) | s5;
      p4 <= (p4 & ~clr) | s4;
      b3 <= (b3 & ~clr) | s3;
      if (cmd_valid && is_rd && open_st) mode <= rd_code;
      case (state)
        S_IDLE: if (cmd_valid) begin
          if (cmd_data == 8'h20 || cmd_data == 8'h77 || cmd_data == 8'hA7) begin
            state <= S_SETUP; pend <= cmd_data;
          end else if (cmd_data == 8'h41) begin
            state <= S_LOAD; idx <= '0;
          end
        end
        S_SETUP: if (cmd_valid) begin
          mode  <= M_STS;
          state <= S_IDLE;
          if (cmd_data == 8'hD0) begin
            if (pend == 8'h20 && !(lock[wblk] && !wp_n)) begin
              state <= S_BUSY; kind <= K_ERASE; blk <= wblk;
              cnt <= CNT_W'(ERASE_CYC); arr_erase_go <= 1'b1;
            end else if (pend == 8'hA7) begin
              state <= S_BUSY; kind <= K_EALL; blk <= '0;
              cnt <= CNT_W'(ERASE_CYC); arr_erase_go <= 1'b1; arr_erase_all <= 1'b1;
            end else if (pend == 8'h77) begin
              state <= S_BUSY; kind <= K_LOCK; blk <= wblk;
              cnt <= CNT_W'(PROG_CYC);
            end
          end
        end
        S_LOAD: if (cmd_valid) begin
          if (!off_ok) begin
            state <= S_IDLE; mode <= M_STS;
          end else begin
            arr_ld <= 1'b1; arr_ld_addr <= cmd_addr; arr_ld_data <= cmd_data;
            idx <= idx + 1'b1;
            blk <= cblk;
            if (idx == LAST_OFF) begin
              mode  <= M_STS;
              state <= S_IDLE;
              if (!(lock[cblk] && !wp_n)) begin
                state <= S_BUSY; kind <= K_PROG;
                cnt <= CNT_W'(PROG_CYC); arr_prog_go <= 1'b1;
              end
            end
          end
        end
        S_BUSY: begin
          if (fin) begin
            state <= S_IDLE;
            if (kind == K_LOCK && !arr_fail) lock[blk] <= 1'b1;
            if (kind == K_ERASE && wp_n) lock[blk] <= 1'b0;
            if (kind == K_EALL && wp_n) lock <= '0;
          end else if (cmd_valid && cmd_data == 8'hB0) begin
            state <= S_SUSP; mode <= M_STS;
          end else cnt <= cnt - 1'b1;
        end
        S_SUSP: if (cmd_valid && cmd_data == 8'hD0) state <= S_BUSY;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (mode)
      M_ARR:   rd_data = arr_rdata;
      M_ID:    rd_data = rd_addr[0] ? DEV_CODE : 8'h07;
      M_STS:   rd_data = {~busy, susp, e5, p4, b3, 3'b000};
      default: rd_data = {1'b0, ~lock[rblk], 6'b000000};
    endcase
  end

  assign rd_mode  = mode;
  assign rdy_busy = ~busy;
  assign arr_hold = susp;
  assign arr_blk  = blk;
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_data,
  input logic [1:0] rd_mode,
  input logic [7:0] rd_data,
  input logic       rdy_busy,
  input logic       arr_prog_go,
  input logic       arr_erase_go,
  input logic       arr_hold
);
  a_r14_ready_matches_status: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd2) |-> (rd_data[7] == rdy_busy));

  a_r14_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd2) |-> (rd_data[2:0] == 3'b000));

  a_r4_start_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_erase_go || arr_prog_go) |-> !rdy_busy);

  a_r6_one_start_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_erase_go, arr_prog_go}));

  a_r8_suspended_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
    arr_hold |-> rdy_busy);

  a_r8_resume_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_hold && cmd_valid && cmd_data == 8'hD0) |=> (!arr_hold && !rdy_busy));

  a_r9_erase_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd2 && rd_data[5] && !cmd_valid) |=> (rd_mode != 2'd2 || rd_data[5]));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk chk_i (.*);

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
  localparam int AW = 16, BW = 3, PW = 3, EC = 40, PC = 20, PL = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, wp_n = 1'b1;
  logic arr_fail = 1'b0, arr_ovp = 1'b0;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = '0, arr_rdata = 8'h5A;
  logic [1:0] rd_mode;
  logic [7:0] rd_data, arr_ld_data;
  logic rdy_busy, arr_prog_go, arr_erase_go, arr_erase_all, arr_hold, arr_ld;
  logic [BW-1:0] arr_blk;
  logic [AW-1:0] arr_ld_addr;
  int nchk = 0, nerr = 0;
  logic exp_e5 = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .BLK_W(BW), .PAGE_W(PW), .ERASE_CYC(EC),
                  .PROG_CYC(PC), .TOP_BOOT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .wp_n(wp_n), .rd_addr(rd_addr), .arr_rdata(arr_rdata),
    .arr_fail(arr_fail), .arr_ovp(arr_ovp), .rd_mode(rd_mode), .rd_data(rd_data),
    .rdy_busy(rdy_busy), .arr_prog_go(arr_prog_go), .arr_erase_go(arr_erase_go),
    .arr_erase_all(arr_erase_all), .arr_hold(arr_hold), .arr_blk(arr_blk),
    .arr_ld(arr_ld), .arr_ld_addr(arr_ld_addr), .arr_ld_data(arr_ld_data));

  function automatic logic [AW-1:0] mk(int b, int o);
    return (AW'(b) << (AW - BW)) | AW'(o);
  endfunction

  function automatic logic [7:0] sts(logic rdy, logic sp, logic e, logic p, logic bb);
    return {rdy, sp, e, p, bb, 3'b000};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic busy_window(string req, int n);
    chk(req, 8'(rdy_busy), 8'h00);
    repeat (n - 1) @(negedge clk);
    chk(req, 8'(rdy_busy), 8'h00);
    @(negedge clk);
    chk(req, 8'(rdy_busy), 8'h01);
  endtask

  task automatic erase(string req, int b);
    wr(mk(b, 0), 8'h20);
    wr(mk(b, 5), 8'hD0);
    chk(req, 8'(arr_erase_go), 8'h01);
    busy_window(req, EC);
  endtask

  task automatic page(int b, logic [7:0] base);
    wr(mk(b, 0), 8'h41);
    for (int i = 0; i < PL; i++) wr(mk(b, i), base + 8'(i));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", 8'(rd_mode), 8'h00);
    chk("R1 ready", 8'(rdy_busy), 8'h01);
    chk("R1 array data", rd_data, 8'h5A);
    wr('0, 8'h70);
    chk("R1 status", rd_data, 8'h80);
    // R2 R3 identifier
    wr('0, 8'h90);
    chk("R2 id mode", 8'(rd_mode), 8'h01);
    rd_addr = '0; #1 chk("R3 maker", rd_data, 8'h07);
    rd_addr = 16'h0001; #1 chk("R3 device", rd_data, 8'h85);
    wr('0, 8'hFF);
    arr_rdata = 8'hC3; #1 chk("R2 array", rd_data, 8'hC3);
    // R4 erase, block from the second write, R11 status mode
    wr(mk(1, 0), 8'h20);
    wr(mk(5, 0), 8'hD0);
    chk("R4 erase go", 8'(arr_erase_go), 8'h01);
    chk("R4 block", 8'(arr_blk), 8'h05);
    chk("R11 status mode", 8'(rd_mode), 8'h02);
    busy_window("R4 busy", EC);
    chk("R4 done", rd_data, 8'h80);
    // R9 fail and stickiness
    arr_fail = 1'b1;
    erase("R9 fail erase", 4);
    arr_fail = 1'b0;
    chk("R9 erase err", rd_data, 8'hA0);
    erase("R9 second erase", 4);
    chk("R9 sticky", rd_data, 8'hA0);
    wr('0, 8'h50);
    chk("R9 clear", rd_data, 8'h80);
    // R6 page program with fail and over-program
    arr_fail = 1'b1; arr_ovp = 1'b1;
    wr(mk(3, 0), 8'h41);
    wr(mk(3, 0), 8'h10);
    chk("R6 load pulse", 8'(arr_ld), 8'h01);
    chk("R6 load data", arr_ld_data, 8'h10);
    for (int i = 1; i < PL; i++) wr(mk(3, i), 8'h10 + 8'(i));
    chk("R6 prog go", 8'(arr_prog_go), 8'h01);
    busy_window("R6 busy", PC);
    arr_fail = 1'b0; arr_ovp = 1'b0;
    chk("R9 program errs", rd_data, 8'h98);
    wr('0, 8'h50);
    // R6 offset error
    wr(mk(3, 0), 8'h41);
    wr(mk(3, 1), 8'hAA);
    chk("R6 offset seq err", rd_data, 8'hB0);
    chk("R6 not started", 8'(rdy_busy), 8'h01);
    wr('0, 8'h50);
    // R7 setup not confirmed
    wr('0, 8'h20);
    wr('0, 8'hFF);
    chk("R7 seq err", rd_data, 8'hB0);
    chk("R7 mode", 8'(rd_mode), 8'h02);
    wr('0, 8'h50);
    chk("R7 clear", rd_data, 8'h80);
    // R8 suspend/resume
    wr(mk(2, 0), 8'h20);
    wr(mk(2, 0), 8'hD0);
    repeat (5) @(negedge clk);
    wr('0, 8'hB0);
    chk("R8 suspended", rd_data, 8'hC0);
    chk("R8 hold", 8'(arr_hold), 8'h01);
    wr('0, 8'hFF);
    chk("R8 read in suspend", 8'(rd_mode), 8'h00);
    wr('0, 8'h20);
    chk("R13 ignored in suspend", 8'(arr_hold), 8'h01);
    wr('0, 8'hD0);
    busy_window("R8 remaining", EC - 5);
    wr('0, 8'h70);
    chk("R8 done", rd_data, 8'h80);
    // R13 ignored while busy
    wr(mk(1, 0), 8'h20);
    wr(mk(1, 0), 8'hD0);
    wr('0, 8'h20);
    wr('0, 8'h41);
    chk("R13 no load", 8'(arr_ld), 8'h00);
    repeat (EC) @(negedge clk);
    wr('0, 8'h70);
    chk("R13 mode", 8'(rd_mode), 8'h02);
    chk("R13 clean", rd_data, 8'h80);
    // R5 lock program and lock status
    wr(mk(2, 0), 8'h77);
    wr(mk(2, 0), 8'hD0);
    busy_window("R5 lock busy", PC);
    wr('0, 8'h71);
    rd_addr = mk(2, 0); #1 chk("R5 locked", rd_data, 8'h00);
    rd_addr = mk(3, 0); #1 chk("R5 unlocked", rd_data, 8'h40);
    // R10 protection
    wp_n = 1'b0;
    wr(mk(2, 0), 8'h20);
    wr(mk(2, 0), 8'hD0);
    chk("R10 erase reject", rd_data, 8'hA0);
    chk("R10 no go", 8'(arr_erase_go), 8'h00);
    wr('0, 8'h50);
    page(2, 8'h30);
    chk("R10 prog reject", rd_data, 8'h90);
    chk("R10 no prog go", 8'(arr_prog_go), 8'h00);
    wr('0, 8'h50);
    wp_n = 1'b1;
    erase("R10 unprotected erase", 2);
    wr('0, 8'h71);
    rd_addr = mk(2, 0); #1 chk("R10 lock cleared", rd_data, 8'h40);
    // R5 erase all
    wr('0, 8'hA7);
    wr('0, 8'hD0);
    chk("R5 all go", 8'(arr_erase_go), 8'h01);
    chk("R5 all flag", 8'(arr_erase_all), 8'h01);
    busy_window("R5 all busy", EC);
    // R12 abort
    wr(mk(6, 0), 8'h20);
    wr(mk(6, 0), 8'hD0);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready", 8'(rdy_busy), 8'h01);
    chk("R12 mode", 8'(rd_mode), 8'h00);
    wr('0, 8'h70);
    chk("R12 status", rd_data, 8'h80);
    // random mix
    exp_e5 = 1'b0;
    for (int it = 0; it < 40; it++) begin
      int unsigned r;
      r = $urandom % 3;
      if (r == 0) begin
        arr_fail = 1'($urandom);
        erase("R4 random erase", int'($urandom % 8));
        exp_e5 = exp_e5 | arr_fail;
        arr_fail = 1'b0;
        chk("R9 random status", rd_data, sts(1'b1, 1'b0, exp_e5, 1'b0, 1'b0));
      end else if (r == 1) begin
        wr('0, 8'h50);
        exp_e5 = 1'b0;
        wr('0, 8'h70);
        chk("R9 random clear", rd_data, 8'h80);
      end else begin
        wr('0, 8'h90);
        rd_addr = AW'($urandom);
        #1 chk("R3 random id", rd_data, rd_addr[0] ? 8'h85 : 8'h07);
        wr('0, 8'h70);
        chk("R14 random status", rd_data, sts(rdy_busy, 1'b0, exp_e5, 1'b0, 1'b0));
      end
    end
    finish_run();
  end
endmodule